// File: doc/BRIEF.md
# Bus Idle Gap Timer

This block decides when a transmitter on a shared single-wire consumer-electronics control bus may begin to drive the line. Once it is armed it counts how long the line has been idle, in half-bit-period ticks supplied by a clock-enable input. When the line has stayed idle for the required time, it raises a ready output. That output holds until the transmitter acknowledges it.

A 3-bit setting selects the required idle time. A nonzero value N selects 2N-1 half-bit ticks, which is 0.5 + (N-1) bit periods. The value 0 selects a default length that is fixed by a synthesis parameter. A start-option input picks what arms the timer. With the option at 0, the software start-of-message pulse arms it. With the option at 1, the end-of-transmission or end-of-reception pulse arms it. Any activity on the line during the count returns the count to zero.

Top module: `idle_gap_timer`

## Requirements
- R1: After reset, `tx_ready` and `busy` are both 0.
- R2: With `gap_sel` = N (1..7) captured at arming, `tx_ready` rises on the clock edge at which the (2N-1)-th `half_tick` seen with `line_idle` = 1 is sampled. On that same edge `busy` drops.
- R3: With `gap_sel` = 0 captured at arming, the required count is the parameter `DEFAULT_TICKS` half-bit ticks.
- R4: With `auto_start` = 0, a `sw_som` pulse arms the timer: `busy` becomes 1 on the next edge. `tx_done` and `rx_done` have no effect.
- R5: With `auto_start` = 1, either `tx_done` or `rx_done` arms the timer. `sw_som` has no effect.
- R6: While `busy` = 1, a cycle with `line_idle` = 0 returns the tick count to zero. Counting resumes from zero once the line is idle again.
- R7: `tx_ready` stays 1 until a cycle with `start_ack` = 1, and reads 0 after that edge. `start_ack` while `tx_ready` = 0 has no effect.
- R8: The gap setting is captured on the arming edge. Later changes to `gap_sel` do not alter a count that is already running.
- R9: An arming event while `busy` = 1 restarts the count from zero. An arming event while `tx_ready` = 1 is ignored, and `tx_ready` stays 1.
- R10: A `half_tick` that falls in the same cycle as the arming event is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle enable per half nominal bit period |
| line_idle | input | 1 | 1 while the bus line is released |
| gap_sel | input | SEL_W | Idle-gap setting (0 selects the default) |
| auto_start | input | 1 | 0: arm on sw_som; 1: arm on tx_done or rx_done |
| sw_som | input | 1 | Software start-of-message pulse |
| tx_done | input | 1 | End-of-transmission pulse |
| rx_done | input | 1 | End-of-reception pulse |
| start_ack | input | 1 | Transmitter takes the ready grant |
| busy | output | 1 | Timer armed and counting |
| tx_ready | output | 1 | Required idle gap has elapsed |

## Verification
The bench builds the block with `DEFAULT_TICKS` = 4. This differs from every odd count that a nonzero setting can produce, so a wrong choice on the default path shows up as a wrong ready edge. The bench pulses `half_tick` once every three clocks, which leaves idle cycles between ticks. That spacing lets the bench test line activity that falls between ticks, arming events that coincide with a tick, and the longest setting (13 ticks) within a few dozen cycles each.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  // Required half-bit ticks for a setting; zero picks the supplied default.
  function automatic int unsigned gap_ticks(input int unsigned sel, input int unsigned dflt);
    if (sel == 0) return dflt;
    return 2 * sel - 1;
  endfunction

  function automatic int unsigned max_ticks(input int unsigned sel_w, input int unsigned dflt);
    int unsigned prog;
    prog = 2 * ((1 << sel_w) - 1) - 1;
    return (prog > dflt) ? prog : dflt;
  endfunction
endpackage

// File: rtl/gap_arm_select.sv
module gap_arm_select (
  input  logic auto_start,
  input  logic sw_som,
  input  logic tx_done,
  input  logic rx_done,
  input  logic ready,
  output logic arm
);
  logic raw;
  always_comb begin
    raw = auto_start ? (tx_done | rx_done) : sw_som;
    // A pending grant swallows further arming events (R9)
    arm = raw & ~ready;
  end
endmodule

// File: rtl/gap_target_latch.sv
module gap_target_latch #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DEFAULT_TICKS = 5,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [SEL_W-1:0] gap_sel,
  output logic [CNT_W-1:0] target
);
  import idle_gap_pkg::*;
  logic [CNT_W-1:0] decoded;

  always_comb decoded = CNT_W'(gap_ticks(int'(gap_sel), DEFAULT_TICKS));

  always_ff @(posedge clk) begin
    if (rst)      target <= CNT_W'(1);
    else if (arm) target <= decoded;
  end

  // R8: the captured target only moves on an arming edge
  a_r8_target_frozen: assert property (@(posedge clk) disable iff (rst)
    !arm |=> $stable(target));
endmodule

// File: rtl/gap_idle_counter.sv
module gap_idle_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             armed,
  input  logic             line_idle,
  input  logic             half_tick,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_comb
    done = armed & ~arm & line_idle & half_tick & (cnt == target - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (arm)              cnt <= '0;
    else if (armed) begin
      if (!line_idle)          cnt <= '0;
      else if (done)           cnt <= '0;
      else if (half_tick)      cnt <= cnt + CNT_W'(1);
    end
  end

  // R6: line activity while counting clears the count
  a_r6_busy_line_clears: assert property (@(posedge clk) disable iff (rst)
    armed && !arm && !line_idle |=> cnt == '0);
  // R2: count stays below the target while armed
  a_r2_below_target: assert property (@(posedge clk) disable iff (rst)
    armed |-> cnt < target);
  // R10: arming cycle restarts from zero whatever the tick
  a_r10_arm_zero: assert property (@(posedge clk) disable iff (rst)
    arm |=> cnt == '0);
endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DEFAULT_TICKS = 5,
  localparam int unsigned MAX_TICKS = idle_gap_pkg::max_ticks(SEL_W, DEFAULT_TICKS),
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic             line_idle,
  input  logic [SEL_W-1:0] gap_sel,
  input  logic             auto_start,
  input  logic             sw_som,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             start_ack,
  output logic             busy,
  output logic             tx_ready
);
  logic             arm;
  logic             done;
  logic [CNT_W-1:0] target;

  gap_arm_select u_sel (
    .auto_start(auto_start), .sw_som(sw_som), .tx_done(tx_done),
    .rx_done(rx_done), .ready(tx_ready), .arm(arm)
  );

  gap_target_latch #(.SEL_W(SEL_W), .DEFAULT_TICKS(DEFAULT_TICKS), .CNT_W(CNT_W)) u_tgt (
    .clk(clk), .rst(rst), .arm(arm), .gap_sel(gap_sel), .target(target)
  );

  gap_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .arm(arm), .armed(busy), .line_idle(line_idle),
    .half_tick(half_tick), .target(target), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_ready <= 1'b0;
    end else begin
      if (arm)       busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done)           tx_ready <= 1'b1;
      else if (start_ack) tx_ready <= 1'b0;
    end
  end

  // R7: grant holds until acknowledged, then clears
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
    tx_ready && !start_ack |=> tx_ready);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    tx_ready && start_ack |=> !tx_ready);
  // R9: counting and granted never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && tx_ready));
  // R2: grant only appears after an idle tick while counting
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tx_ready ##1 tx_ready |-> $past(half_tick && line_idle && busy));
endmodule

// File: tb/idle_gap_timer_test.sv
module idle_gap_timer_test;
  localparam int DEF = 4;
  logic clk = 0, rst = 1;
  logic half_tick = 0, line_idle = 1, auto_start = 0;
  logic sw_som = 0, tx_done = 0, rx_done = 0, start_ack = 0;
  logic [2:0] gap_sel = 3'd1;
  logic busy, tx_ready;

  idle_gap_timer #(.SEL_W(3), .DEFAULT_TICKS(DEF)) uut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .line_idle(line_idle),
    .gap_sel(gap_sel), .auto_start(auto_start), .sw_som(sw_som),
    .tx_done(tx_done), .rx_done(rx_done), .start_ack(start_ack),
    .busy(busy), .tx_ready(tx_ready)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int phase = 0;
  bit force_tick = 0, no_tick = 0;
  string cur = "R1";
  int m_armed = 0, m_cnt = 0, m_ready = 0, m_tgt = 1;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int trig, eff, done, na, nc, nr;
    if (rst) begin
      m_armed = 0; m_cnt = 0; m_ready = 0; m_tgt = 1;
      return;
    end
    trig = auto_start ? (tx_done | rx_done) : sw_som;
    eff  = trig && !m_ready;
    done = m_armed && !eff && line_idle && half_tick && (m_cnt == m_tgt - 1);
    na = m_armed; nc = m_cnt; nr = m_ready;
    if (eff) begin
      nc = 0;
      m_tgt = (gap_sel == 0) ? DEF : 2 * int'(gap_sel) - 1;
    end else if (m_armed) begin
      if (!line_idle) nc = 0;
      else if (done) nc = 0;
      else if (half_tick) nc = m_cnt + 1;
    end
    if (eff) na = 1; else if (done) na = 0;
    if (done) nr = 1; else if (start_ack) nr = 0;
    m_armed = na; m_cnt = nc; m_ready = nr;
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      half_tick = force_tick || (!no_tick && phase == 0);
      phase = (phase + 1) % 3;
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(cur, int'(tx_ready), m_ready, "tx_ready");
      chk(cur, int'(busy), m_armed, "busy");
      sw_som = 0; tx_done = 0; rx_done = 0; start_ack = 0; force_tick = 0;
    end
  endtask

  task automatic ack();
    start_ack = 1; cyc(1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL all watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(3);
    rst = 0;
    cur = "R1"; cyc(2);
    chk("R1", int'(tx_ready), 0, "reset tx_ready");
    chk("R1", int'(busy), 0, "reset busy");

    // R2 shortest and longest settings with R4 software start
    cur = "R2"; gap_sel = 1; sw_som = 1; cyc(1);
    chk("R4", int'(busy), 1, "armed by sw_som");
    cyc(6); chk("R2", int'(tx_ready), 1, "sel1 ready");
    cur = "R7"; cyc(5); chk("R7", int'(tx_ready), 1, "ready holds"); ack();
    chk("R7", int'(tx_ready), 0, "ack clears");
    cur = "R2"; gap_sel = 7; sw_som = 1; cyc(1); cyc(38);
    chk("R2", int'(tx_ready), 0, "sel7 not yet");
    cyc(4); chk("R2", int'(tx_ready), 1, "sel7 ready"); ack();
    gap_sel = 3; sw_som = 1; cyc(20); ack();

    // R3 default length
    cur = "R3"; gap_sel = 0; sw_som = 1; cyc(15);
    chk("R3", int'(tx_ready), 1, "default ready"); ack();

    // R4 end pulses ignored in software mode
    cur = "R4"; tx_done = 1; cyc(1); rx_done = 1; cyc(3);
    chk("R4", int'(busy), 0, "done pulses ignored");

    // R5 automatic mode
    cur = "R5"; auto_start = 1; gap_sel = 2; sw_som = 1; cyc(4);
    chk("R5", int'(busy), 0, "sw_som ignored");
    tx_done = 1; cyc(1); chk("R5", int'(busy), 1, "tx_done arms"); cyc(12); ack();
    rx_done = 1; cyc(1); chk("R5", int'(busy), 1, "rx_done arms"); cyc(12); ack();

    // R6 line activity restarts
    cur = "R6"; gap_sel = 3; tx_done = 1; cyc(8);
    line_idle = 0; cyc(4); line_idle = 1; cyc(10);
    chk("R6", int'(tx_ready), 0, "restart delays ready");
    cyc(8); ack();

    // R8 setting change mid-count
    cur = "R8"; gap_sel = 1; rx_done = 1; cyc(1); gap_sel = 7; cyc(5);
    chk("R8", int'(tx_ready), 1, "captured setting used"); ack();

    // R9 retrigger and trigger while ready
    cur = "R9"; gap_sel = 4; tx_done = 1; cyc(12); tx_done = 1; cyc(15);
    chk("R9", int'(tx_ready), 0, "retrigger restarts");
    cyc(8); tx_done = 1; cyc(3);
    chk("R9", int'(tx_ready), 1, "ready kept on trigger"); ack();

    // R10 tick in arming cycle not counted
    cur = "R10"; gap_sel = 1; no_tick = 1; force_tick = 1; rx_done = 1; cyc(1);
    cyc(3); chk("R10", int'(tx_ready), 0, "arming tick ignored");
    force_tick = 1; cyc(1); chk("R10", int'(tx_ready), 1, "next tick counts");
    no_tick = 0; ack();

    // R7 ack while idle has no effect
    cur = "R7"; ack(); cyc(2); chk("R7", int'(tx_ready), 0, "stray ack");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule